// File: doc/BRIEF.md
# Translation Buffer Demap Command Decoder

This block takes one demap request, given as a 64-bit address word, and turns it into invalidations on a small translation buffer that it holds. A start strobe latches the address together with the current partition, primary context and secondary context. The control then walks every entry, one per clock. Each entry that the decoded command matches loses its valid bit. Lookup and replacement belong to other blocks.

Bits 7:6 of the address choose the kind of demap. There are three kinds: one page, one context, or the whole partition. A context selector in bits 5:4 picks which context applies. The reserved selector value turns page and context demaps into no-ops. It does not affect a partition-wide demap. A load port writes entries and a probe port reads back their valid bits, so the store can be preset and observed from outside.

Top module: `tlb_demap`

## Requirements
- R1: Address bits 7:6 pick the demap kind: 0 = page, 1 = context, 2 = whole partition, 3 = invalid. An accepted invalid command raises `cmdError` for exactly the one cycle after the start edge, leaves `busy` low and changes no entry.
- R2: Address bits 5:4 select the context: 0 = primary context input, 1 = secondary context input, 3 = context zero.
- R3: Selector value 2 marks the command as ignored. A page or context demap with this selector still scans, but clears no entry.
- R4: A whole-partition demap clears every valid entry whose partition equals `partId`, whatever the selector holds. Entries of other partitions stay.
- R5: A page demap clears an entry only when all four fields match: its page number equals address bits 63:13, its partition equals `partId`, its real flag equals address bit 9, and its context equals the selected context.
- R6: A context demap clears every entry whose partition and context both match, regardless of page number and real flag.
- R7: After an accepted valid-kind start, `busy` is high for exactly ENTRIES cycles, one entry scanned per cycle. `done` then pulses high for one cycle in the cycle after the last entry.
- R8: A start strobe while `busy` is high is ignored and does not alter the scan in progress or any entry.
- R9: With `busy` low, a load writes page number, partition, context, real flag and valid into entry `loadIdx`. A load while `busy` is high is ignored. `probeValid` shows the valid bit of entry `probeIdx` combinationally.
- R10: After reset every entry is invalid, and `busy`, `done` and `cmdError` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startStrobe | input | 1 | Start a demap with the current command inputs |
| demapAddr | input | 64 | Demap address word: page number, real flag, kind, selector |
| partId | input | 3 | Partition of the command |
| primaryCtx | input | 13 | Context used for selector 0 |
| secondaryCtx | input | 13 | Context used for selector 1 |
| loadEn | input | 1 | Write one entry |
| loadIdx | input | 3 | Entry to write |
| loadVpn | input | 51 | Page number to write |
| loadPart | input | 3 | Partition to write |
| loadCtx | input | 13 | Context to write |
| loadReal | input | 1 | Real flag to write |
| loadValid | input | 1 | Valid bit to write |
| probeIdx | input | 3 | Entry whose valid bit is shown |
| probeValid | output | 1 | Valid bit of entry probeIdx |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse after the last scanned entry |
| cmdError | output | 1 | One-cycle pulse for an invalid demap kind |

## Verification
The bench targets the reserved selector. It checks that page and context demaps with that selector clear nothing, and that a partition-wide demap with it still clears. A design that applied the ignore flag to all three kinds, or to none, would leave extra entries or remove wrong ones. The bench also sets up entries that differ from a command in only one field: real flag, partition, context or page. A page match missing any one field compare would clear those entries. Further cases are starts and loads issued during a scan, which a design that failed to gate them would act on, and the invalid kind, where a slip would change entries or start a scan.

// File: rtl/demapPkg.sv
package demapPkg;
  typedef enum logic [1:0] {
    KIND_PAGE = 2'd0,
    KIND_CTX  = 2'd1,
    KIND_ALL  = 2'd2,
    KIND_BAD  = 2'd3
  } demapKind_e;

  typedef enum logic [1:0] {
    SEL_PRIMARY   = 2'd0,
    SEL_SECONDARY = 2'd1,
    SEL_RESERVED  = 2'd2,
    SEL_NUCLEUS   = 2'd3
  } ctxSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic scanEn;
  } demapStrobe_t;

  localparam int KIND_LSB = 6;
  localparam int SEL_LSB  = 4;
  localparam int REAL_BIT = 9;
endpackage

// File: rtl/demapCtrl.sv
module demapCtrl
  import demapPkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStrobe,
  input  logic [1:0]       startKind,
  output demapStrobe_t     strobe,
  output logic [IDX_W-1:0] scanIdx,
  output logic             busy,
  output logic             done,
  output logic             cmdError
);
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_FIN} ctrlState_e;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  ctrlState_e state;
  logic       accept;
  logic       isBad;

  assign accept = startStrobe && (state != ST_SCAN);
  assign isBad  = (startKind == KIND_BAD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      scanIdx  <= '0;
      cmdError <= 1'b0;
    end else begin
      cmdError <= accept && isBad;
      case (state)
        ST_SCAN: begin
          if (scanIdx == LAST_IDX) begin
            state <= ST_FIN;
          end else begin
            scanIdx <= scanIdx + 1'b1;
          end
        end
        default: begin
          if (accept && !isBad) begin
            state   <= ST_SCAN;
            scanIdx <= '0;
          end else begin
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  always_comb begin
    strobe.capture = accept && !isBad;
    strobe.scanEn  = (state == ST_SCAN);
  end

  assign busy = (state == ST_SCAN);
  assign done = (state == ST_FIN);
endmodule

// File: rtl/demapStore.sv
module demapStore
  import demapPkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int VA_W     = 64,
  parameter int PAGE_LSB = 13,
  parameter int PART_W   = 3,
  parameter int CTX_W    = 13,
  parameter int IDX_W    = $clog2(ENTRIES),
  parameter int VPN_W    = VA_W - PAGE_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  demapStrobe_t      strobe,
  input  logic [IDX_W-1:0]  scanIdx,
  input  logic [VA_W-1:0]   demapAddr,
  input  logic [PART_W-1:0] partId,
  input  logic [CTX_W-1:0]  primaryCtx,
  input  logic [CTX_W-1:0]  secondaryCtx,
  input  logic              loadEn,
  input  logic [IDX_W-1:0]  loadIdx,
  input  logic [VPN_W-1:0]  loadVpn,
  input  logic [PART_W-1:0] loadPart,
  input  logic [CTX_W-1:0]  loadCtx,
  input  logic              loadReal,
  input  logic              loadValid,
  input  logic [IDX_W-1:0]  probeIdx,
  output logic              probeValid
);
  // latched command
  demapKind_e        cmdKind;
  logic [VPN_W-1:0]  cmdVpn;
  logic              cmdReal;
  logic [PART_W-1:0] cmdPart;
  logic [CTX_W-1:0]  cmdCtx;
  logic              cmdIgnore;

  ctxSel_e           selNow;
  logic [CTX_W-1:0]  ctxNow;

  assign selNow = ctxSel_e'(demapAddr[SEL_LSB +: 2]);

  always_comb begin
    case (selNow)
      SEL_PRIMARY:   ctxNow = primaryCtx;
      SEL_SECONDARY: ctxNow = secondaryCtx;
      default:       ctxNow = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdKind   <= KIND_PAGE;
      cmdVpn    <= '0;
      cmdReal   <= 1'b0;
      cmdPart   <= '0;
      cmdCtx    <= '0;
      cmdIgnore <= 1'b1;
    end else if (strobe.capture) begin
      cmdKind   <= demapKind_e'(demapAddr[KIND_LSB +: 2]);
      cmdVpn    <= demapAddr[VA_W-1:PAGE_LSB];
      cmdReal   <= demapAddr[REAL_BIT];
      cmdPart   <= partId;
      cmdCtx    <= ctxNow;
      cmdIgnore <= (selNow == SEL_RESERVED);
    end
  end

  // entry storage
  logic [VPN_W-1:0]  vpnArr  [ENTRIES];
  logic [PART_W-1:0] partArr [ENTRIES];
  logic [CTX_W-1:0]  ctxArr  [ENTRIES];
  logic              realArr [ENTRIES];
  logic              validArr[ENTRIES];

  logic partHit, ctxHit, pageHit, scanHit;

  always_comb begin
    partHit = (partArr[scanIdx] == cmdPart);
    ctxHit  = (ctxArr[scanIdx] == cmdCtx);
    pageHit = (vpnArr[scanIdx] == cmdVpn) && (realArr[scanIdx] == cmdReal);
    case (cmdKind)
      KIND_PAGE: scanHit = !cmdIgnore && partHit && ctxHit && pageHit;
      KIND_CTX:  scanHit = !cmdIgnore && partHit && ctxHit;
      KIND_ALL:  scanHit = partHit;
      default:   scanHit = 1'b0;
    endcase
  end

  logic loadOk;
  assign loadOk = loadEn && !strobe.scanEn;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(e);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validArr[e] <= 1'b0;
      end else if (loadOk && loadIdx == MY_IDX) begin
        validArr[e] <= loadValid;
      end else if (strobe.scanEn && scanIdx == MY_IDX && scanHit) begin
        validArr[e] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (loadOk && loadIdx == MY_IDX) begin
        vpnArr[e]  <= loadVpn;
        partArr[e] <= loadPart;
        ctxArr[e]  <= loadCtx;
        realArr[e] <= loadReal;
      end
    end
  end

  assign probeValid = validArr[probeIdx];
endmodule

// File: rtl/tlb_demap.sv
module tlb_demap
  import demapPkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int VA_W     = 64,
  parameter int PAGE_LSB = 13,
  parameter int PART_W   = 3,
  parameter int CTX_W    = 13,
  parameter int IDX_W    = $clog2(ENTRIES),
  parameter int VPN_W    = VA_W - PAGE_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStrobe,
  input  logic [VA_W-1:0]   demapAddr,
  input  logic [PART_W-1:0] partId,
  input  logic [CTX_W-1:0]  primaryCtx,
  input  logic [CTX_W-1:0]  secondaryCtx,
  input  logic              loadEn,
  input  logic [IDX_W-1:0]  loadIdx,
  input  logic [VPN_W-1:0]  loadVpn,
  input  logic [PART_W-1:0] loadPart,
  input  logic [CTX_W-1:0]  loadCtx,
  input  logic              loadReal,
  input  logic              loadValid,
  input  logic [IDX_W-1:0]  probeIdx,
  output logic              probeValid,
  output logic              busy,
  output logic              done,
  output logic              cmdError
);
  demapStrobe_t     strobe;
  logic [IDX_W-1:0] scanIdx;

  demapCtrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startStrobe(startStrobe),
    .startKind  (demapAddr[KIND_LSB +: 2]),
    .strobe     (strobe),
    .scanIdx    (scanIdx),
    .busy       (busy),
    .done       (done),
    .cmdError   (cmdError)
  );

  demapStore #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .PAGE_LSB(PAGE_LSB),
    .PART_W(PART_W), .CTX_W(CTX_W), .IDX_W(IDX_W), .VPN_W(VPN_W)
  ) u_store (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .scanIdx     (scanIdx),
    .demapAddr   (demapAddr),
    .partId      (partId),
    .primaryCtx  (primaryCtx),
    .secondaryCtx(secondaryCtx),
    .loadEn      (loadEn),
    .loadIdx     (loadIdx),
    .loadVpn     (loadVpn),
    .loadPart    (loadPart),
    .loadCtx     (loadCtx),
    .loadReal    (loadReal),
    .loadValid   (loadValid),
    .probeIdx    (probeIdx),
    .probeValid  (probeValid)
  );
endmodule

// File: rtl/demapChecker.sv
module demapChecker #(
  parameter int VA_W = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            startStrobe,
  input logic [VA_W-1:0] demapAddr,
  input logic            busy,
  input logic            done,
  input logic            cmdError
);
  p_bad_kind_flags_r1: assert property (@(posedge clk) disable iff (!rstN)
    (startStrobe && !busy && demapAddr[7:6] == 2'd3) |=> (cmdError && !busy));

  p_error_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |=> !cmdError);

  p_scan_begins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (startStrobe && !busy && demapAddr[7:6] != 2'd3) |=> busy);

  p_done_follows_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startStrobe && !$past(done)) |=> (busy || done));

  p_quiet_reset_r10: assert property (@(posedge clk)
    !rstN |=> (!busy && !done && !cmdError));
endmodule

bind tlb_demap demapChecker #(.VA_W(VA_W)) u_demapChecker (
  .clk        (clk),
  .rstN       (rstN),
  .startStrobe(startStrobe),
  .demapAddr  (demapAddr),
  .busy       (busy),
  .done       (done),
  .cmdError   (cmdError)
);

// File: tb/tlb_demap_test.sv
`timescale 1ns/1ps
module tlb_demap_test;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startStrobe = 1'b0;
  logic [63:0] demapAddr = '0;
  logic [2:0]  partId = '0;
  logic [12:0] primaryCtx = '0;
  logic [12:0] secondaryCtx = '0;
  logic        loadEn = 1'b0;
  logic [2:0]  loadIdx = '0;
  logic [50:0] loadVpn = '0;
  logic [2:0]  loadPart = '0;
  logic [12:0] loadCtx = '0;
  logic        loadReal = 1'b0;
  logic        loadValid = 1'b0;
  logic [2:0]  probeIdx = '0;
  logic        probeValid, busy, done, cmdError;

  always #2.5 clk = ~clk;

  tlb_demap uut (.*);

  int nChecks = 0;
  int nFails = 0;

  logic [50:0] mVpn [N];
  logic [2:0]  mPart[N];
  logic [12:0] mCtx [N];
  logic        mReal[N];
  logic        mValid[N];
  logic [50:0] vpnPool[4];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mkAddr(logic [50:0] vpn, logic rl, logic [1:0] kind, logic [1:0] sel);
    return {vpn, 3'b000, rl, 1'b0, kind, sel, 4'b0000};
  endfunction

  function automatic logic [12:0] selCtx(logic [1:0] sel, logic [12:0] pc, logic [12:0] sc);
    if (sel == 2'd0) return pc;
    if (sel == 2'd1) return sc;
    return 13'd0;
  endfunction

  function automatic bit expHit(int e, logic [63:0] a, logic [2:0] p, logic [12:0] c);
    logic [1:0] kind = a[7:6];
    logic       ign = (a[5:4] == 2'd2);
    bit pm = (mPart[e] == p);
    bit cm = (mCtx[e] == c);
    bit vm = (mVpn[e] == a[63:13]) && (mReal[e] == a[9]);
    case (kind)
      2'd0: return !ign && pm && cm && vm;
      2'd1: return !ign && pm && cm;
      2'd2: return pm;
      default: return 0;
    endcase
  endfunction

  task automatic loadEntry(int idx, logic [50:0] v, logic [2:0] p, logic [12:0] c, logic rl, logic vl);
    @(negedge clk);
    loadEn = 1; loadIdx = 3'(idx); loadVpn = v; loadPart = p; loadCtx = c;
    loadReal = rl; loadValid = vl;
    @(negedge clk);
    loadEn = 0;
    mVpn[idx] = v; mPart[idx] = p; mCtx[idx] = c; mReal[idx] = rl; mValid[idx] = vl;
  endtask

  task automatic checkAll(string tag);
    for (int e = 0; e < N; e++) begin
      probeIdx = 3'(e);
      #0.5;
      chk(probeValid === mValid[e], tag, probeValid, mValid[e]);
    end
  endtask

  task automatic runDemap(logic [63:0] a, logic [2:0] p, logic [12:0] pc, logic [12:0] sc, string tag);
    logic [12:0] c = selCtx(a[5:4], pc, sc);
    @(negedge clk);
    demapAddr = a; partId = p; primaryCtx = pc; secondaryCtx = sc; startStrobe = 1;
    @(negedge clk);
    startStrobe = 0;
    if (a[7:6] == 2'd3) begin
      chk(cmdError === 1'b1, "R1 error pulse", cmdError, 1);
      chk(busy === 1'b0, "R1 busy stays low", busy, 0);
      @(negedge clk);
      chk(cmdError === 1'b0, "R1 error one cycle", cmdError, 0);
    end else begin
      for (int i = 1; i <= N + 1; i++) begin
        chk(busy === (i <= N), "R7 busy window", busy, i <= N);
        chk(done === (i == N + 1), "R7 done timing", done, i == N + 1);
        @(negedge clk);
      end
      for (int e = 0; e < N; e++)
        if (mValid[e] && expHit(e, a, p, c)) mValid[e] = 0;
    end
    checkAll(tag);
  endtask

  initial begin
    #100000;
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int e = 0; e < N; e++) mValid[e] = 0;
    for (int k = 0; k < 4; k++) vpnPool[k] = {19'h1A2B3, 30'h0, 2'(k)};
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    chk(busy === 0 && done === 0 && cmdError === 0, "R10 outputs after reset", {busy, done, cmdError}, 0);
    checkAll("R10 entries invalid");

    // R9 load then probe
    loadEntry(0, vpnPool[0], 3'd1, 13'd7, 0, 1);
    loadEntry(1, vpnPool[0], 3'd1, 13'd7, 1, 1);   // differs in real flag
    loadEntry(2, vpnPool[0], 3'd2, 13'd7, 0, 1);   // differs in partition
    loadEntry(3, vpnPool[0], 3'd1, 13'd9, 0, 1);   // differs in context
    loadEntry(4, vpnPool[1], 3'd1, 13'd7, 0, 1);   // differs in page
    loadEntry(5, vpnPool[2], 3'd1, 13'd9, 1, 1);
    loadEntry(6, vpnPool[3], 3'd1, 13'd0, 0, 1);
    loadEntry(7, vpnPool[3], 3'd2, 13'd0, 0, 1);
    checkAll("R9 load and probe");

    // R3 reserved selector suppresses page and context demaps
    runDemap(mkAddr(vpnPool[0], 0, 2'd0, 2'd2), 3'd1, 13'd0, 13'd0, "R3 page ignored");
    runDemap(mkAddr(vpnPool[0], 0, 2'd1, 2'd2), 3'd1, 13'd0, 13'd0, "R3 context ignored");
    // R5 page demap with primary context: only entry 0 goes (R2 selector 0)
    runDemap(mkAddr(vpnPool[0], 0, 2'd0, 2'd0), 3'd1, 13'd7, 13'd9, "R5 R2 page primary");
    // R6 context demap with secondary context (R2 selector 1)
    runDemap(mkAddr(vpnPool[0], 0, 2'd1, 2'd1), 3'd1, 13'd7, 13'd9, "R6 R2 context secondary");
    // R2 selector 3 picks context zero
    runDemap(mkAddr(vpnPool[0], 0, 2'd1, 2'd3), 3'd1, 13'd7, 13'd9, "R2 nucleus context");
    // R1 invalid kind changes nothing
    runDemap(mkAddr(vpnPool[1], 0, 2'd3, 2'd0), 3'd1, 13'd7, 13'd9, "R1 invalid no change");
    // R4 whole-partition demap with reserved selector
    runDemap(mkAddr(vpnPool[0], 0, 2'd2, 2'd2), 3'd2, 13'd0, 13'd0, "R4 all despite ignore");

    // R8 / R9: start and load during a scan
    loadEntry(0, vpnPool[2], 3'd4, 13'd3, 0, 1);
    @(negedge clk);
    demapAddr = mkAddr(vpnPool[3], 1, 2'd0, 2'd0); partId = 3'd5; primaryCtx = 13'd1;
    startStrobe = 1;
    @(negedge clk);
    startStrobe = 0;
    @(negedge clk);
    demapAddr = mkAddr(vpnPool[0], 0, 2'd2, 2'd0); partId = 3'd4; startStrobe = 1;
    loadEn = 1; loadIdx = 3'd0; loadValid = 0; loadVpn = '0; loadPart = 3'd4; loadCtx = '0; loadReal = 0;
    @(negedge clk);
    startStrobe = 0; loadEn = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(busy === 0, "R8 no second scan", busy, 0);
    checkAll("R8 R9 start and load ignored while busy");

    // random mix
    for (int t = 0; t < 60; t++) begin
      if (t % 4 == 0)
        for (int e = 0; e < N; e++)
          loadEntry(e, vpnPool[$urandom_range(3)], 3'($urandom_range(1)),
                    ($urandom_range(3) == 0) ? 13'd0 : 13'($urandom_range(1) ? 7 : 9),
                    1'($urandom_range(1)), 1'($urandom_range(4) != 0));
      runDemap(mkAddr(vpnPool[$urandom_range(3)], 1'($urandom_range(1)),
                      2'($urandom_range(3)), 2'($urandom_range(3))),
               3'($urandom_range(1)), 13'd7, 13'd9, "R5 R6 R4 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule